// File: doc/BRIEF.md
# Command and Status Register Slave for a Timed Engine

This block is an AXI4-Lite slave that holds five 32-bit words used to set up and run a timed peripheral engine, such as a pulse-width generator. Software writes an enable flag, an 8-bit period and an 8-bit high-time into the first three words. The low bits of those words drive the engine directly.

Every accepted write to one of the first four words raises a single-cycle command pulse, one pulse line per word. The pulse for the fourth word acts as the engine's start. When the engine finishes it raises a done pulse. That pulse sets a sticky flag in the fifth word, which software polls and then clears by writing it.

The write strobes are registered. Each pulse therefore shows up in the same clock in which the freshly written value becomes visible in its register. The status word has a single updating process that merges the hardware set with software writes.

Top module: `timer_ctrl_regs`

## Requirements
- R1: While aresetn is low at a rising clock edge, all five words, cmd_pulse, bvalid and rvalid become 0. Afterwards every word reads as 0.
- R2: A write is accepted at an edge where awvalid and wvalid are both high and bvalid is low. In that cycle awready and wready are both high, and they are never high apart. At the next edge bvalid rises with bresp = 2'b00 and stays high until an edge where bready is high.
- R3: A read is accepted at an edge where arvalid and arready are high, and arready is high exactly when rvalid is low. At the next edge rvalid rises with rresp = 2'b00 and rdata holding the addressed word. rvalid and rdata hold until an edge where rready is high.
- R4: A software write changes only the bytes whose wstrb bit is set (wstrb[k] covers wdata[8k+7:8k]). The other bytes keep their value.
- R5: eng_enable is bit 0 of the word at 0x00. eng_period is bits 7:0 of the word at 0x04. eng_width is bits 7:0 of the word at 0x08.
- R6: An accepted write to word index i (byte address 4*i, i from 0 to 3) drives cmd_pulse[i] high for exactly one cycle, starting at the edge after acceptance. Writes to 0x10 or beyond produce no pulse, and at most one pulse bit is ever high.
- R7: An edge where eng_done is high sets bit 0 of the word at 0x10. The bit then stays 1 until software writes that word.
- R8: If eng_done is high at the same edge that a software write to 0x10 is accepted, the whole write is discarded and bit 0 becomes 1.
- R9: Without a concurrent eng_done, a software write to 0x10 stores its data like any other word, so writing 0 clears the flag.
- R10: Byte addresses above 0x10 read as 0. Writes to them get an OKAY response but change no word and raise no pulse. Address bits 1:0 are ignored.
- R11: The first write to 0x0C after reset raises exactly one start pulse on cmd_pulse[3], with no earlier access needed. Each later write to 0x0C raises another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| awaddr | input | ADDR_W | Write address (byte) |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address (byte) |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| eng_enable | output | 1 | Engine enable |
| eng_period | output | FIELD_W | Engine period setting |
| eng_width | output | FIELD_W | Engine high-time setting |
| cmd_pulse | output | 4 | Per-word write pulses; bit 3 starts the engine |
| eng_done | input | 1 | Completion pulse from the engine |

## Verification
The assertions assume that a master keeps awvalid and wvalid low during reset and never leaves one of them raised without the other for long. They also assume eng_done is a clean synchronous level that is sampled at each edge. The bench drives every address and data change half a clock away from the rising edge. It raises awvalid and wvalid together, except in one scenario that raises awvalid alone on purpose. It pulses eng_done for exactly one cycle, either alone or lined up with a status write. While it tests the handshake holds, it keeps bready and rready low for several cycles.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int DATA_W     = 32;
  localparam int STRB_W     = DATA_W / 8;
  localparam int NUM_REGS   = 5;
  localparam int NUM_PULSES = 4;
  localparam int STATUS_IDX = 4;
  localparam int ENABLE_IDX = 0;
  localparam int PERIOD_IDX = 1;
  localparam int WIDTH_IDX  = 2;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [STRB_W-1:0] strb_t;

  // Byte-lane merge: each set enable bit replaces one byte of the current word.
  function automatic word_t merge_bytes(input word_t cur, input word_t nxt, input strb_t be);
    word_t res;
    res = cur;
    for (int b = 0; b < STRB_W; b++) begin
      if (be[b]) res[b*8 +: 8] = nxt[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/tcr_wr_chan.sv
module tcr_wr_chan
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic             aclk,
  input  logic             aresetn,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic             awvalid,
  input  logic             wvalid,
  input  logic             bready,
  output logic             awready,
  output logic             wready,
  output logic             bvalid,
  output logic [1:0]       bresp,
  output logic             wr_fire,
  output logic [IDX_W-1:0] wr_idx
);
  logic bvalid_q;
  logic accept;

  // Address and data are taken together, one transaction at a time.
  assign accept  = awvalid && wvalid && !bvalid_q;
  assign awready = accept;
  assign wready  = accept;
  assign wr_fire = accept;
  assign wr_idx  = awaddr[ADDR_W-1:2];
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge aclk) begin
    if (!aresetn)      bvalid_q <= 1'b0;
    else if (accept)   bvalid_q <= 1'b1;
    else if (bready)   bvalid_q <= 1'b0;
  end
endmodule

// File: rtl/tcr_rd_chan.sv
module tcr_rd_chan
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic                         aclk,
  input  logic                         aresetn,
  input  logic [ADDR_W-1:0]            araddr,
  input  logic                         arvalid,
  input  logic                         rready,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic                         arready,
  output logic                         rvalid,
  output logic [DATA_W-1:0]            rdata,
  output logic [1:0]                   rresp,
  output logic                         rd_fire
);
  logic             rvalid_q;
  word_t            rdata_q;
  word_t            rd_mux;
  logic [IDX_W-1:0] rd_idx;

  assign rd_idx  = araddr[ADDR_W-1:2];
  assign arready = !rvalid_q;
  assign rd_fire = arvalid && !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  // Unmapped indices fall through to zero.
  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == IDX_W'(r)) rd_mux = regs[r];
    end
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tcr_regfile.sv
module tcr_regfile
  import tcr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                            aclk,
  input  logic                            aresetn,
  input  logic                            wr_fire,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [STRB_W-1:0]               wstrb,
  input  logic                            eng_done,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [NUM_PULSES-1:0]           cmd_pulse,
  output logic                            status_sw_hit
);
  logic [NUM_REGS-1:0] wr_sel;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel[r] = wr_fire && (wr_idx == IDX_W'(r));
  end

  assign status_sw_hit = wr_sel[STATUS_IDX];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == STATUS_IDX) begin : g_status
      // Single process: the hardware set outranks a same-cycle software write.
      always_ff @(posedge aclk) begin
        if (!aresetn)       regs[r] <= '0;
        else if (eng_done)  regs[r][0] <= 1'b1;
        else if (wr_sel[r]) regs[r] <= merge_bytes(regs[r], wdata, wstrb);
      end
    end else begin : g_plain
      always_ff @(posedge aclk) begin
        if (!aresetn)       regs[r] <= '0;
        else if (wr_sel[r]) regs[r] <= merge_bytes(regs[r], wdata, wstrb);
      end
    end
  end

  // Registered strobes line up with the cycle the written data becomes visible.
  always_ff @(posedge aclk) begin
    if (!aresetn) cmd_pulse <= '0;
    else          cmd_pulse <= wr_sel[NUM_PULSES-1:0];
  end
endmodule

// File: rtl/timer_ctrl_regs.sv
module timer_ctrl_regs
  import tcr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 8
) (
  input  logic               aclk,
  input  logic               aresetn,
  input  logic [ADDR_W-1:0]  awaddr,
  input  logic               awvalid,
  output logic               awready,
  input  logic [31:0]        wdata,
  input  logic [3:0]         wstrb,
  input  logic               wvalid,
  output logic               wready,
  output logic [1:0]         bresp,
  output logic               bvalid,
  input  logic               bready,
  input  logic [ADDR_W-1:0]  araddr,
  input  logic               arvalid,
  output logic               arready,
  output logic [31:0]        rdata,
  output logic [1:0]         rresp,
  output logic               rvalid,
  input  logic               rready,
  output logic               eng_enable,
  output logic [FIELD_W-1:0] eng_period,
  output logic [FIELD_W-1:0] eng_width,
  output logic [3:0]         cmd_pulse,
  input  logic               eng_done
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            wr_fire;
  logic [IDX_W-1:0]                wr_idx;
  logic                            rd_fire;
  logic                            status_bit;
  logic                            status_sw_hit;
  logic                            unused_lsbs;

  assign unused_lsbs = ^{awaddr[1:0], araddr[1:0], rd_fire};

  tcr_wr_chan #(.ADDR_W(ADDR_W)) wr_i (
    .aclk(aclk), .aresetn(aresetn), .awaddr(awaddr), .awvalid(awvalid),
    .wvalid(wvalid), .bready(bready), .awready(awready), .wready(wready),
    .bvalid(bvalid), .bresp(bresp), .wr_fire(wr_fire), .wr_idx(wr_idx)
  );

  tcr_regfile #(.IDX_W(IDX_W)) rf_i (
    .aclk(aclk), .aresetn(aresetn), .wr_fire(wr_fire), .wr_idx(wr_idx),
    .wdata(wdata), .wstrb(wstrb), .eng_done(eng_done), .regs(regs),
    .cmd_pulse(cmd_pulse), .status_sw_hit(status_sw_hit)
  );

  tcr_rd_chan #(.ADDR_W(ADDR_W)) rd_i (
    .aclk(aclk), .aresetn(aresetn), .araddr(araddr), .arvalid(arvalid),
    .rready(rready), .regs(regs), .arready(arready), .rvalid(rvalid),
    .rdata(rdata), .rresp(rresp), .rd_fire(rd_fire)
  );

  assign status_bit = regs[STATUS_IDX][0];
  assign eng_enable = regs[ENABLE_IDX][0];
  assign eng_period = regs[PERIOD_IDX][FIELD_W-1:0];
  assign eng_width  = regs[WIDTH_IDX][FIELD_W-1:0];
endmodule

// File: rtl/tcr_chk.sv
module tcr_chk (
  input logic        aclk,
  input logic        aresetn,
  input logic        awready,
  input logic        wready,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic [3:0]  cmd_pulse,
  input logic        wr_fire,
  input logic        eng_done,
  input logic        status_bit,
  input logic        status_sw_hit
);
  // R2
  aw_w_pair_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    awready |-> wready);
  // R2
  bresp_okay_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid |-> bresp == 2'b00);
  // R2
  bvalid_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid && !bready |=> bvalid);
  // R3
  rvalid_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R6
  pulse_onehot_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    $onehot0(cmd_pulse));
  // R6
  pulse_source_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    (|cmd_pulse) |-> $past(wr_fire));
  // R6
  pulse_single_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    (|cmd_pulse) |=> cmd_pulse == 4'b0000);
  // R7
  done_sets_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    eng_done |=> status_bit);
  // R7
  status_sticky_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    status_bit && !status_sw_hit |=> status_bit);
endmodule

bind timer_ctrl_regs tcr_chk chk_i (
  .aclk(aclk), .aresetn(aresetn), .awready(awready), .wready(wready),
  .bvalid(bvalid), .bready(bready), .bresp(bresp), .rvalid(rvalid),
  .rready(rready), .rdata(rdata), .cmd_pulse(cmd_pulse), .wr_fire(wr_fire),
  .eng_done(eng_done), .status_bit(status_bit), .status_sw_hit(status_sw_hit)
);

// File: tb/timer_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module timer_ctrl_regs_tb_top;
  logic        aclk = 1'b0;
  logic        aresetn = 1'b0;
  logic [7:0]  awaddr = '0;
  logic        awvalid = 1'b0;
  logic        awready;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready = 1'b0;
  logic [7:0]  araddr = '0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rvalid;
  logic        rready = 1'b0;
  logic        eng_enable;
  logic [7:0]  eng_period;
  logic [7:0]  eng_width;
  logic [3:0]  cmd_pulse;
  logic        eng_done;
  logic        tb_done = 1'b0;
  logic        model_done = 1'b0;
  logic        model_on = 1'b0;
  int          model_cnt = 0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2 aclk = ~aclk;

  assign eng_done = tb_done | model_done;

  // Engine stand-in: one done pulse a few cycles after each start.
  always @(posedge aclk) begin
    model_done <= 1'b0;
    if (model_on) begin
      if (cmd_pulse[3]) model_cnt <= 6;
      else if (model_cnt > 0) begin
        model_cnt <= model_cnt - 1;
        if (model_cnt == 1) model_done <= 1'b1;
      end
    end
  end

  timer_ctrl_regs dut_i (
    .aclk(aclk), .aresetn(aresetn), .awaddr(awaddr), .awvalid(awvalid),
    .awready(awready), .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid),
    .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready), .rdata(rdata),
    .rresp(rresp), .rvalid(rvalid), .rready(rready), .eng_enable(eng_enable),
    .eng_period(eng_period), .eng_width(eng_width), .cmd_pulse(cmd_pulse),
    .eng_done(eng_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Write with optional same-cycle done and a response hold of bhold cycles.
  task automatic do_write(input logic [7:0] addr, input logic [31:0] data,
                          input logic [3:0] strb, input bit with_done, input int bhold,
                          output logic [3:0] p1, output logic [3:0] p2);
    @(negedge aclk);
    awaddr = addr; wdata = data; wstrb = strb;
    awvalid = 1'b1; wvalid = 1'b1; bready = 1'b0; tb_done = with_done;
    #1;
    check(awready && wready, "R2", "ready pair on accept", {awready, wready}, 2'b11);
    @(negedge aclk);
    awvalid = 1'b0; wvalid = 1'b0; tb_done = 1'b0;
    p1 = cmd_pulse;
    check(bvalid && bresp == 2'b00, "R2", "bvalid/bresp", {bvalid, bresp}, 3'b100);
    for (int i = 0; i < bhold; i++) begin
      @(negedge aclk);
      check(bvalid == 1'b1, "R2", "bvalid held", bvalid, 1);
    end
    bready = 1'b1;
    @(negedge aclk);
    p2 = cmd_pulse;
    check(bvalid == 1'b0, "R2", "bvalid drop", bvalid, 0);
    bready = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    logic [3:0] a, b;
    do_write(addr, data, 4'hF, 1'b0, 0, a, b);
  endtask

  task automatic do_read(input logic [7:0] addr, input int rhold, output logic [31:0] val);
    logic [31:0] first;
    @(negedge aclk);
    araddr = addr; arvalid = 1'b1; rready = 1'b0;
    #1;
    check(arready == 1'b1, "R3", "arready idle", arready, 1);
    @(negedge aclk);
    arvalid = 1'b0;
    first = rdata;
    check(rvalid && rresp == 2'b00, "R3", "rvalid/rresp", {rvalid, rresp}, 3'b100);
    for (int i = 0; i < rhold; i++) begin
      @(negedge aclk);
      check(rvalid && arready == 1'b0 && rdata == first, "R3", "rdata held", rdata, first);
    end
    val = rdata;
    rready = 1'b1;
    @(negedge aclk);
    check(rvalid == 1'b0, "R3", "rvalid drop", rvalid, 0);
    rready = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] v;
    do_read(addr, 0, v);
    check(v == exp, req, $sformatf("readback @0x%02h", addr), v, exp);
  endtask

  task automatic t_reset;
    check(cmd_pulse == 0 && !bvalid && !rvalid, "R1", "outputs after reset",
          {cmd_pulse, bvalid, rvalid}, 0);
    check({eng_enable, eng_period, eng_width} == 0, "R1", "engine fields", {eng_enable, eng_period, eng_width}, 0);
    for (int i = 0; i < 5; i++) expect_reg(8'(4 * i), 32'h0, "R1");
  endtask

  task automatic t_first_start;
    logic [3:0] a, b;
    do_write(8'h0C, 32'h1, 4'hF, 1'b0, 0, a, b);
    check(a == 4'b1000 && b == 4'b0000, "R11", "first start pulse", {a, b}, 8'h80);
    do_write(8'h0C, 32'h1, 4'hF, 1'b0, 0, a, b);
    check(a == 4'b1000 && b == 4'b0000, "R11", "repeat start pulse", {a, b}, 8'h80);
  endtask

  task automatic t_config;
    logic [3:0] a, b;
    do_write(8'h00, 32'h1, 4'hF, 1'b0, 0, a, b);
    check(a == 4'b0001 && b == 0, "R6", "pulse idx0", {a, b}, 8'h10);
    do_write(8'h04, 32'hEE, 4'hF, 1'b0, 0, a, b);
    check(a == 4'b0010 && b == 0, "R6", "pulse idx1", {a, b}, 8'h20);
    do_write(8'h08, 32'h88, 4'hF, 1'b0, 0, a, b);
    check(a == 4'b0100 && b == 0, "R6", "pulse idx2", {a, b}, 8'h40);
    check(eng_enable == 1 && eng_period == 8'hEE && eng_width == 8'h88, "R5", "engine fields",
          {eng_enable, eng_period, eng_width}, {1'b1, 8'hEE, 8'h88});
    expect_reg(8'h04, 32'hEE, "R3");
    expect_reg(8'h0A, 32'h88, "R10");
  endtask

  task automatic t_strobes;
    logic [3:0] a, b;
    wr(8'h04, 32'h11223344);
    do_write(8'h04, 32'hAABBCCDD, 4'b0101, 1'b0, 0, a, b);
    expect_reg(8'h04, 32'h11BB33DD, "R4");
    check(eng_period == 8'hDD, "R5", "period low byte", eng_period, 8'hDD);
    do_write(8'h00, 32'h0000_0000, 4'b0000, 1'b0, 0, a, b);
    check(eng_enable == 1'b1, "R4", "no-strobe write keeps enable", eng_enable, 1);
  endtask

  task automatic t_out_of_range;
    logic [3:0] a, b;
    do_write(8'h14, 32'hFFFFFFFF, 4'hF, 1'b0, 0, a, b);
    check(a == 0 && b == 0, "R10", "no pulse above map", {a, b}, 0);
    expect_reg(8'h14, 32'h0, "R10");
    expect_reg(8'h00, 32'h1, "R10");
    expect_reg(8'h10, 32'h0, "R10");
    do_write(8'h10, 32'h0, 4'hF, 1'b0, 0, a, b);
    check(a == 0 && b == 0, "R6", "no pulse for status write", {a, b}, 0);
  endtask

  task automatic t_status;
    @(negedge aclk); tb_done = 1'b1;
    @(negedge aclk); tb_done = 1'b0;
    repeat (5) @(negedge aclk);
    expect_reg(8'h10, 32'h1, "R7");
    wr(8'h10, 32'h0);
    expect_reg(8'h10, 32'h0, "R9");
    wr(8'h10, 32'h0000_0100);
    expect_reg(8'h10, 32'h0000_0100, "R9");
    wr(8'h10, 32'h0);
  endtask

  task automatic t_collision;
    logic [3:0] a, b;
    do_write(8'h10, 32'h0, 4'hF, 1'b1, 0, a, b);
    expect_reg(8'h10, 32'h1, "R8");
    do_write(8'h10, 32'h12345670, 4'hF, 1'b1, 0, a, b);
    expect_reg(8'h10, 32'h1, "R8");
    wr(8'h10, 32'h0);
  endtask

  task automatic t_holds;
    logic [3:0] a, b;
    logic [31:0] v;
    do_write(8'h08, 32'h5A, 4'hF, 1'b0, 3, a, b);
    check(a == 4'b0100 && b == 0, "R6", "pulse with held response", {a, b}, 8'h40);
    do_read(8'h08, 3, v);
    check(v == 32'h5A, "R3", "held read data", v, 32'h5A);
    @(negedge aclk);
    awaddr = 8'h04; wdata = 32'h77; wstrb = 4'hF; awvalid = 1'b1;
    #1;
    check(awready == 1'b0 && wready == 1'b0, "R2", "no accept without wvalid", {awready, wready}, 0);
    @(negedge aclk);
    check(!bvalid && cmd_pulse == 0, "R2", "no response without wvalid", {bvalid, cmd_pulse}, 0);
    awvalid = 1'b0;
    expect_reg(8'h04, 32'h11BB33DD, "R2");
  endtask

  task automatic t_engine_loop;
    logic [31:0] v;
    int tries;
    model_on = 1'b1;
    for (int k = 0; k < 2; k++) begin
      wr(8'h0C, 32'h1);
      tries = 0;
      v = 0;
      while (v[0] == 1'b0 && tries < 20) begin
        do_read(8'h10, 0, v);
        tries++;
      end
      check(v == 32'h1, "R7", "engine done seen", v, 1);
      wr(8'h10, 32'h0);
    end
    model_on = 1'b0;
    expect_reg(8'h10, 32'h0, "R9");
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge aclk);
    aresetn = 1'b1;
    @(negedge aclk);
    t_reset();
    t_first_start();
    t_config();
    t_strobes();
    t_out_of_range();
    t_status();
    t_collision();
    t_holds();
    t_engine_loop();
    report();
  end
endmodule